// File: doc/BRIEF.md
# Per-Pin Interrupt Event Detector

This block watches up to 32 already-synchronized input pins and turns selected pin activity into interrupt requests. Each pin owns a control word on a 32-bit register bus. A 4-bit trigger code inside that word selects the kind of activity that counts as an event:

- no detection at all
- a held low level
- a held high level
- a rising edge
- a falling edge
- either edge

Every event sets that pin's flag in a common pending register. Software reads the pending register and clears the flags it has handled by writing ones to them. One interrupt line is raised whenever any flag is pending.

The bus is a simple single-cycle interface. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address. Edges are found by comparing each pin with its own value from the previous clock. That history is kept in every cycle, whatever the trigger code, so a code change never produces a false edge.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset every control word reads 0, the pending register reads 0 and irq_out is low.
- R2: The control word of pin n is at byte address 4*n (0x00 to 0x7C). Its trigger code is held in bits 19:16, and every other bit reads 0 whatever was written. Writing 0 to the word turns detection off for that pin. Any address that is neither a control word nor the pending register reads 0.
- R3: With code 0xC (high level) or 0x8 (low level), the pin's pending flag is set on every clock while the pin holds the selected level.
- R4: With code 0x9, a 0-to-1 change of the pin sets its flag, and a 1-to-0 change does not.
- R5: With code 0xA, a 1-to-0 change of the pin sets its flag, and a 0-to-1 change does not.
- R6: With code 0xB, a change in either direction sets the pin's flag.
- R7: Code 0x0, and every code not listed in R3 to R6, never sets a flag, whatever the pin does.
- R8: The pending register at address 0xA0 holds one flag per pin, with bit n belonging to pin n. Writing a 1 to bit n clears that flag. Writing 0 to a bit leaves it unchanged, and writing all ones clears every flag.
- R9: When an event and a clearing write hit the same flag in the same clock, the flag stays set.
- R10: irq_out is high exactly when at least one pending flag is set.
- R11: Writing a new trigger code while the pin level is steady sets no edge flag.
- R12: In a level mode, a clearing write has no lasting effect while the pin still holds the level. The flag can be cleared once the level has gone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions take it for granted that pin_in is already synchronous to clk and changes at most once per clock. They also take it for granted that reset is held for at least one clock edge, so the pin history and the flags start from known values. The bench drives pins and bus signals only on the falling clock edge and keeps every pin low while reset is asserted. It returns all trigger codes to 0 and clears all flags between scenarios, so each edge it looks at is a deliberate one.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [3:0] {
    TRIG_OFF    = 4'h0,
    TRIG_LVL_LO = 4'h8,
    TRIG_RISE   = 4'h9,
    TRIG_FALL   = 4'hA,
    TRIG_BOTH   = 4'hB,
    TRIG_LVL_HI = 4'hC
  } trig_code_e;

  // Decide whether a pin produces an event this cycle.
  function automatic logic trig_hit(input logic [3:0] code,
                                    input logic cur, input logic prev);
    logic hit;
    case (code)
      TRIG_LVL_LO: hit = ~cur;
      TRIG_LVL_HI: hit = cur;
      TRIG_RISE:   hit = cur & ~prev;
      TRIG_FALL:   hit = ~cur & prev;
      TRIG_BOTH:   hit = cur ^ prev;
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction

  // True for the codes that look at a change of level.
  function automatic logic trig_is_edge(input logic [3:0] code);
    return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH);
  endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs #(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 4,
  parameter int CFG_LSB = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hA0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NPINS-1:0]       status_q,
  output logic [NPINS*CFG_W-1:0] cfg_flat,
  output logic [NPINS-1:0]       clr_vec
);
  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [CFG_W-1:0]  cfg_q [NPINS];
  logic [PIDX_W-1:0] pidx;
  logic              in_pin_region;
  logic              hit_status;

  assign pidx          = bus_addr[PIDX_W+1:2];
  assign in_pin_region = (bus_addr[1:0] == 2'b00) &&
                         (bus_addr[ADDR_W-1:2] < ADDR_W'(NPINS));
  assign hit_status    = (bus_addr == STAT_ADDR);
  assign clr_vec       = (bus_wr && hit_status) ? bus_wdata[NPINS-1:0] : '0;

  for (genvar g = 0; g < NPINS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (bus_wr && in_pin_region && (pidx == PIDX_W'(g))) begin
        cfg_q[g] <= bus_wdata[CFG_LSB +: CFG_W];
      end
    end
    assign cfg_flat[g*CFG_W +: CFG_W] = cfg_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (in_pin_region) begin
      bus_rdata[CFG_LSB +: CFG_W] = cfg_q[pidx];
    end else if (hit_status) begin
      bus_rdata[NPINS-1:0] = status_q;
    end
  end
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
  import pirq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CFG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  output logic [NPINS-1:0]       pin_prev,
  output logic [NPINS-1:0]       evt_vec,
  output logic [NPINS-1:0]       edge_sel
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [CFG_W-1:0] code;
    assign code = cfg_flat[g*CFG_W +: CFG_W];

    // History is kept whatever the code, so a code change never sees a stale level.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev[g] <= 1'b0;
      else        pin_prev[g] <= pin_in[g];
    end

    assign evt_vec[g]  = trig_hit(code, pin_in[g], pin_prev[g]);
    assign edge_sel[g] = trig_is_edge(code);
  end
endmodule

// File: rtl/pirq_status.sv
module pirq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_vec,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] status_q,
  output logic             irq_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | evt_vec;
  end

  assign irq_out = |status_q;
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl #(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CFG_W   = 4,
  parameter int CFG_LSB = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq_out
);
  logic [NPINS*CFG_W-1:0] cfg_flat;
  logic [NPINS-1:0]       clr_vec;
  logic [NPINS-1:0]       evt_vec;
  logic [NPINS-1:0]       edge_sel;
  logic [NPINS-1:0]       pin_prev;
  logic [NPINS-1:0]       status_q;

  pirq_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_W(CFG_W), .CFG_LSB(CFG_LSB), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_q(status_q),
    .cfg_flat(cfg_flat), .clr_vec(clr_vec)
  );

  pirq_detect #(.NPINS(NPINS), .CFG_W(CFG_W)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_flat(cfg_flat),
    .pin_prev(pin_prev), .evt_vec(evt_vec), .edge_sel(edge_sel)
  );

  pirq_status #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .clr_vec(clr_vec),
    .status_q(status_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_prev,
  input logic [NPINS-1:0] evt_vec,
  input logic [NPINS-1:0] edge_sel,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] status_q,
  input logic             irq_out
);
  localparam logic [NPINS-1:0] ZERO = '0;

  p_irq_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (status_q != ZERO));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_vec)) == ZERO));

  p_edge_needs_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec & edge_sel & ~(pin_in ^ pin_prev)) == ZERO);
endmodule

bind pin_event_ctrl pirq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_prev(pin_prev),
  .evt_vec(evt_vec), .edge_sel(edge_sel), .clr_vec(clr_vec),
  .status_q(status_q), .irq_out(irq_out)
);

// File: tb/sim_pin_event_ctrl.sv
module sim_pin_event_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [7:0] PEND = 8'hA0;

  pin_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic [3:0] code);
    return {12'h000, code, 16'h0000};
  endfunction

  // Caller stands on a falling edge; returns on the next falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pend_chk(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(PEND, d);
    chk(tag, d, exp);
    chk("R10", {31'b0, irq_out}, {31'b0, exp != 32'h0});
  endtask

  task automatic tidy();
    for (int p = 0; p < 32; p++) wr(8'(p*4), 32'h0);
    pin_in = '0;
    tick(2);
    wr(PEND, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1", d, 32'h0);
    rd(8'h7C, d); chk("R1", d, 32'h0);
    rd(PEND, d);  chk("R1", d, 32'h0);
    chk("R1", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R2", d, 32'h000F_0000);
    wr(8'h7C, ctl(4'h9));
    rd(8'h7C, d); chk("R2", d, 32'h0009_0000);
    rd(8'h80, d); chk("R2", d, 32'h0);
    wr(8'h14, 32'h0);
    rd(8'h14, d); chk("R2", d, 32'h0);
    // pin 5 is disabled again: a level change must set nothing
    pin_in[5] = 1'b1; tick(2);
    pend_chk("R2", 32'h0);
    tidy();
  endtask

  task automatic t_rise();
    wr(8'd12, ctl(4'h9));
    pin_in[3] = 1'b1; tick(1);
    pend_chk("R4", 32'h8);
    wr(PEND, 32'h8);
    pend_chk("R4", 32'h0);
    pin_in[3] = 1'b0; tick(2);
    pend_chk("R4", 32'h0);
    tidy();
  endtask

  task automatic t_fall();
    wr(8'd28, ctl(4'hA));
    pin_in[7] = 1'b1; tick(2);
    pend_chk("R5", 32'h0);
    pin_in[7] = 1'b0; tick(1);
    pend_chk("R5", 32'h80);
    tidy();
  endtask

  task automatic t_both();
    wr(8'd36, ctl(4'hB));
    pin_in[9] = 1'b1; tick(1);
    pend_chk("R6", 32'h200);
    wr(PEND, 32'h200);
    pend_chk("R6", 32'h0);
    pin_in[9] = 1'b0; tick(1);
    pend_chk("R6", 32'h200);
    tidy();
  endtask

  task automatic t_level();
    wr(8'd48, ctl(4'hC));
    pin_in[12] = 1'b1; tick(1);
    pend_chk("R3", 32'h1000);
    wr(PEND, 32'h1000);
    pend_chk("R12", 32'h1000);
    pin_in[12] = 1'b0; tick(1);
    wr(PEND, 32'h1000);
    pend_chk("R12", 32'h0);
    tidy();
    wr(8'd52, ctl(4'h8));   // pin 13 already low
    tick(1);
    pend_chk("R3", 32'h2000);
    pin_in[13] = 1'b1; tick(1);
    wr(PEND, 32'h2000);
    pend_chk("R12", 32'h0);
    tidy();
  endtask

  task automatic t_disabled();
    wr(8'd80, ctl(4'h5));
    wr(8'd84, ctl(4'hF));
    wr(8'd88, ctl(4'h0));
    for (int i = 0; i < 4; i++) begin
      pin_in[22:20] = ~pin_in[22:20]; tick(1);
    end
    pend_chk("R7", 32'h0);
    tidy();
  endtask

  task automatic t_no_false_edge();
    pin_in[22] = 1'b1; tick(2);
    wr(8'd88, ctl(4'h9)); tick(2);
    pend_chk("R11", 32'h0);
    wr(8'd88, ctl(4'hB)); tick(2);
    pend_chk("R11", 32'h0);
    tidy();
  endtask

  task automatic t_collide();
    wr(8'd100, ctl(4'h9));
    pin_in[25] = 1'b1;
    wr(PEND, 32'h0200_0000);   // clear and edge land on the same clock
    pend_chk("R9", 32'h0200_0000);
    wr(PEND, 32'h0200_0000);
    pend_chk("R9", 32'h0);
    tidy();
  endtask

  task automatic t_w1c();
    wr(8'd4, ctl(4'h9));
    wr(8'd124, ctl(4'h9));
    pin_in[1] = 1'b1; pin_in[31] = 1'b1; tick(1);
    pend_chk("R8", 32'h8000_0002);
    wr(PEND, 32'h0);
    pend_chk("R8", 32'h8000_0002);
    wr(PEND, 32'h0000_0002);
    pend_chk("R8", 32'h8000_0000);
    wr(PEND, 32'hFFFF_FFFF);
    pend_chk("R8", 32'h0);
    tidy();
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disabled();
    t_no_false_edge();
    t_collide();
    t_w1c();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule